// File: doc/BRIEF.md
# Power-Register Access Command Executor

This block sits on the controller side of a host mailbox. When the host rings the doorbell, the block reads a command code, a sub-command and a size field. It decodes a packed request from the mailbox write buffer and performs the byte-wide register accesses that the request describes on a power-controller register file. The register file has 16-bit addresses and a synchronous port.

Three operations are supported: a batch write, a batch read and a masked read-modify-write. Accesses run one per cycle in buffer order. Read results land in the mailbox read buffer. A one-cycle done strobe closes every command, including a rejected one. Error status stays visible until the next command is taken.

Top module: `pwr_cmd_exec`

## Requirements
- R1: Only command code 0xFF is executed. Any other code ends the command with `err_o`=1, `err_code_o`=0x01 and no register access.
- R2: Sub-command 0 is a batch write of N items. Item i's address is little-endian in write-buffer bytes 2i (low) and 2i+1 (high). Its data byte is at byte 2N+i. The size field must equal 3N. Register i receives its data byte.
- R3: Sub-command 1 is a batch read of N items with addresses packed as in R2 and a size field of 2N. Item i's register value is returned in read-buffer byte i, and every other read-buffer byte reads 0.
- R4: Sub-command 2 is a masked update with size 4. Write-buffer bytes 0..1 hold the address, byte 2 the value and byte 3 the mask. The register is read, then written in the very next cycle at the same address with (old & ~mask) | (value & mask).
- R5: A batch item count N must be in 1..5. A size field of 0, one that is not a multiple of the per-item size, or one implying N>5 fails with `err_o`=1, `err_code_o`=0x01 and no access. The same applies to a masked update whose size is not 4.
- R6: A sub-command other than 0, 1 or 2 fails with `err_o`=1, `err_code_o`=0x01 and no access.
- R7: If the doorbell is sampled at clock edge K, access i of the command is presented in the cycle following edge K+i. The accesses come in buffer order, one per cycle, with no gaps.
- R8: `done_o` is high for exactly one cycle, N+2 cycles after the accepting edge, where N is the number of register accesses (0 for a rejected command).
- R9: `err_o` and `err_code_o` are loaded when a command is taken (0 and 0x00 on success). They hold until the next accepted doorbell. The read buffer is cleared when a command is taken.
- R10: A doorbell while `busy_o` is high is ignored: no extra accesses, no extra done pulse, no change to the running command.
- R11: `busy_o` is high from the accepting edge until `done_o` rises, and it is low while `done_o` is high.
- R12: After reset, `busy_o`, `done_o`, `err_o`, `rf_en_o` and the whole read buffer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| db_ring_i | input | 1 | Doorbell strobe from the mailbox |
| db_code_i | input | 8 | Command code |
| db_sub_i | input | 4 | Sub-command |
| db_size_i | input | 8 | Size field in bytes |
| mbx_wbuf_i | input | 128 | Write buffer, byte j at bits 8j+7..8j |
| mbx_rbuf_o | output | 128 | Read buffer, byte j at bits 8j+7..8j |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Error flag of the last taken command |
| err_code_o | output | 8 | Error code of the last taken command |
| busy_o | output | 1 | Command in progress |
| rf_en_o | output | 1 | Register access enable |
| rf_we_o | output | 1 | Access is a write |
| rf_addr_o | output | 16 | Register address |
| rf_wdata_o | output | 8 | Write data |
| rf_rdata_i | input | 8 | Read data, valid the cycle after a read access |

## Verification
The hardest condition to reach from the ports is a second doorbell landing in the middle of a running batch. The bench waits until the first access has been presented, then pulses the doorbell with a valid read request and checks that the access log, the read buffer and the done timing still match the first command alone. A second hard case is the masked update whose write depends on read data returned one cycle earlier. The register-file model in the bench returns data from its own array, and the bench compares the written byte against its own shadow copy of that array. Random requests include deliberately broken sizes, codes and sub-commands, so each rejection path is exercised among valid traffic.

// File: rtl/pce_pkg.sv
package pce_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_RMW   = 2'd2,
      OP_NONE  = 2'd3
   } pce_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FINISH = 2'd2
   } pce_state_e;

   localparam int unsigned SUB_WRITE = 0;
   localparam int unsigned SUB_READ  = 1;
   localparam int unsigned SUB_RMW   = 2;

endpackage

// File: rtl/pce_decode.sv
module pce_decode
   import pce_pkg::*;
#(
   parameter int unsigned       MAX_ITEMS  = 5,
   parameter int unsigned       ADDR_BYTES = 2,
   parameter int unsigned       CODE_W     = 8,
   parameter int unsigned       SUB_W      = 4,
   parameter int unsigned       SIZE_W     = 8,
   parameter int unsigned       CNT_W      = 3,
   parameter logic [CODE_W-1:0] CMD_CODE   = 8'hFF
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic [SUB_W-1:0]  sub_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic              ok_o,
   output pce_op_e           op_o,
   output logic [CNT_W-1:0]  n_acc_o
);

   localparam int unsigned WR_STRIDE = ADDR_BYTES + 1;
   localparam int unsigned RD_STRIDE = ADDR_BYTES;
   localparam int unsigned RMW_SIZE  = ADDR_BYTES + 2;

   logic [MAX_ITEMS:1] wr_hit;
   logic [MAX_ITEMS:1] rd_hit;

   // one comparator per legal item count
   for (genvar k = 1; k <= MAX_ITEMS; k++) begin : g_count
      assign wr_hit[k] = (int'(size_i) == int'(WR_STRIDE * k));
      assign rd_hit[k] = (int'(size_i) == int'(RD_STRIDE * k));
   end

   always_comb begin
      ok_o    = 1'b0;
      op_o    = OP_NONE;
      n_acc_o = '0;
      if (code_i == CMD_CODE) begin
         case (int'(sub_i))
            SUB_WRITE: begin
               for (int k = 1; k <= int'(MAX_ITEMS); k++) begin
                  if (wr_hit[k]) begin
                     ok_o    = 1'b1;
                     op_o    = OP_WRITE;
                     n_acc_o = CNT_W'(k);
                  end
               end
            end
            SUB_READ: begin
               for (int k = 1; k <= int'(MAX_ITEMS); k++) begin
                  if (rd_hit[k]) begin
                     ok_o    = 1'b1;
                     op_o    = OP_READ;
                     n_acc_o = CNT_W'(k);
                  end
               end
            end
            SUB_RMW: begin
               if (int'(size_i) == int'(RMW_SIZE)) begin
                  ok_o    = 1'b1;
                  op_o    = OP_RMW;
                  n_acc_o = CNT_W'(2);
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pce_seq.sv
module pce_seq
   import pce_pkg::*;
#(
   parameter int unsigned MAX_ITEMS  = 5,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WBUF_BYTES = 16,
   parameter int unsigned CNT_W      = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ring_i,
   input  logic                    dec_ok_i,
   input  pce_op_e                 dec_op_i,
   input  logic [CNT_W-1:0]        dec_n_i,
   input  logic [WBUF_BYTES*8-1:0] wbuf_i,
   input  logic [BYTE_W-1:0]       rf_rdata_i,
   output logic                    accept_o,
   output logic                    busy_o,
   output logic                    finish_o,
   output logic                    rf_en_o,
   output logic                    rf_we_o,
   output logic [ADDR_W-1:0]       rf_addr_o,
   output logic [BYTE_W-1:0]       rf_wdata_o,
   output logic                    cap_o,
   output logic [CNT_W-1:0]        cap_idx_o
);

   localparam int unsigned ADDR_BYTES = ADDR_W / 8;
   localparam int unsigned WBUF_W     = WBUF_BYTES * 8;

   pce_state_e        state_q;
   pce_op_e           op_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  idx_q;
   logic              bad_q;
   logic [WBUF_W-1:0] buf_q;
   logic              last_acc;
   logic [BYTE_W-1:0] upd_val;
   logic [BYTE_W-1:0] upd_msk;
   logic [BYTE_W-1:0] batch_data;

   assign accept_o = ring_i && (state_q == ST_IDLE);
   assign busy_o   = (state_q != ST_IDLE);
   assign finish_o = (state_q == ST_FINISH);
   assign last_acc = (idx_q == cnt_q - 1'b1);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         cnt_q   <= '0;
         idx_q   <= '0;
         bad_q   <= 1'b0;
         buf_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (ring_i) begin
                  buf_q   <= wbuf_i;
                  op_q    <= dec_op_i;
                  cnt_q   <= dec_ok_i ? dec_n_i : '0;
                  bad_q   <= !dec_ok_i;
                  idx_q   <= '0;
                  state_q <= dec_ok_i ? ST_ACCESS : ST_FINISH;
               end
            end
            ST_ACCESS: begin
               idx_q <= idx_q + 1'b1;
               if (last_acc) state_q <= ST_FINISH;
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
               bad_q   <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // operand extraction from the latched request
   always_comb begin
      upd_val    = buf_q[8*ADDR_BYTES +: BYTE_W];
      upd_msk    = buf_q[8*(ADDR_BYTES+1) +: BYTE_W];
      batch_data = buf_q[8*(int'(ADDR_BYTES)*int'(cnt_q) + int'(idx_q)) +: BYTE_W];
      if (op_q == OP_RMW) begin
         rf_addr_o  = buf_q[0 +: ADDR_W];
         rf_wdata_o = (rf_rdata_i & ~upd_msk) | (upd_val & upd_msk);
      end else begin
         rf_addr_o  = buf_q[int'(idx_q)*int'(ADDR_W) +: ADDR_W];
         rf_wdata_o = batch_data;
      end
   end

   assign rf_en_o   = (state_q == ST_ACCESS);
   assign rf_we_o   = rf_en_o && ((op_q == OP_WRITE) || ((op_q == OP_RMW) && (idx_q != '0)));
   assign cap_o     = rf_en_o && (op_q == OP_READ);
   assign cap_idx_o = idx_q;

   a_r4_rmw_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rf_en_o && !rf_we_o && op_q == OP_RMW) |=> (rf_en_o && rf_we_o && rf_addr_o == $past(rf_addr_o)));

   a_r7_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ACCESS && !last_acc) |=> (state_q == ST_ACCESS && idx_q == $past(idx_q) + 1'b1));

   a_r5_no_access_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_q |-> !rf_en_o);

   a_r10_request_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> ($stable(buf_q) && $stable(op_q) && $stable(cnt_q)));

endmodule

// File: rtl/pce_result.sv
module pce_result
   import pce_pkg::*;
#(
   parameter int unsigned RBUF_BYTES = 16,
   parameter int unsigned MAX_ITEMS  = 5,
   parameter int unsigned CNT_W      = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    clear_i,
   input  logic                    cap_i,
   input  logic [CNT_W-1:0]        cap_idx_i,
   input  logic [BYTE_W-1:0]       rdata_i,
   output logic [RBUF_BYTES*8-1:0] rbuf_o
);

   logic             pend_q;
   logic [CNT_W-1:0] pidx_q;

   // read data arrives one cycle after the access
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
      end else begin
         pend_q <= cap_i;
         pidx_q <= cap_idx_i;
      end
   end

   for (genvar b = 0; b < RBUF_BYTES; b++) begin : g_lane
      if (b < MAX_ITEMS) begin : g_live
         logic [BYTE_W-1:0] lane_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni || clear_i) lane_q <= '0;
            else if (pend_q && int'(pidx_q) == b) lane_q <= rdata_i;
         end
         assign rbuf_o[8*b +: BYTE_W] = lane_q;
      end else begin : g_zero
         assign rbuf_o[8*b +: BYTE_W] = '0;
      end
   end

   a_r9_clear_on_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (rbuf_o == '0));

endmodule

// File: rtl/pwr_cmd_exec.sv
module pwr_cmd_exec
   import pce_pkg::*;
#(
   parameter int unsigned       CODE_W     = 8,
   parameter int unsigned       SUB_W      = 4,
   parameter int unsigned       SIZE_W     = 8,
   parameter int unsigned       ADDR_W     = 16,
   parameter int unsigned       WBUF_BYTES = 16,
   parameter int unsigned       RBUF_BYTES = 16,
   parameter int unsigned       MAX_ITEMS  = 5,
   parameter int unsigned       ERR_W      = 8,
   parameter logic [CODE_W-1:0] CMD_CODE   = 8'hFF,
   parameter logic [ERR_W-1:0]  ERR_FORMAT = 8'h01
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    db_ring_i,
   input  logic [CODE_W-1:0]       db_code_i,
   input  logic [SUB_W-1:0]        db_sub_i,
   input  logic [SIZE_W-1:0]       db_size_i,
   input  logic [WBUF_BYTES*8-1:0] mbx_wbuf_i,
   output logic [RBUF_BYTES*8-1:0] mbx_rbuf_o,
   output logic                    done_o,
   output logic                    err_o,
   output logic [ERR_W-1:0]        err_code_o,
   output logic                    busy_o,
   output logic                    rf_en_o,
   output logic                    rf_we_o,
   output logic [ADDR_W-1:0]       rf_addr_o,
   output logic [7:0]              rf_wdata_o,
   input  logic [7:0]              rf_rdata_i
);

   localparam int unsigned ADDR_BYTES = ADDR_W / 8;
   localparam int unsigned CNT_W      = $clog2(MAX_ITEMS + 2);

   initial begin : p_param_check
      assert (ADDR_W % 8 == 0 && ADDR_W >= 8)
         else $error("ADDR_W must be a whole number of bytes");
      assert ((ADDR_BYTES + 1) * MAX_ITEMS <= WBUF_BYTES)
         else $error("write buffer too small for MAX_ITEMS");
      assert (ADDR_BYTES + 2 <= WBUF_BYTES)
         else $error("write buffer too small for masked update");
      assert (MAX_ITEMS <= RBUF_BYTES && MAX_ITEMS >= 1)
         else $error("read buffer too small for MAX_ITEMS");
      assert ((ADDR_BYTES + 1) * MAX_ITEMS < (1 << SIZE_W))
         else $error("size field too narrow");
   end

   logic             dec_ok;
   pce_op_e          dec_op;
   logic [CNT_W-1:0] dec_n;
   logic             accept;
   logic             finish;
   logic             cap;
   logic [CNT_W-1:0] cap_idx;
   logic             done_q;
   logic             err_q;
   logic [ERR_W-1:0] ecode_q;

   pce_decode #(
      .MAX_ITEMS (MAX_ITEMS),
      .ADDR_BYTES(ADDR_BYTES),
      .CODE_W    (CODE_W),
      .SUB_W     (SUB_W),
      .SIZE_W    (SIZE_W),
      .CNT_W     (CNT_W),
      .CMD_CODE  (CMD_CODE)
   ) i_decode (
      .code_i (db_code_i),
      .sub_i  (db_sub_i),
      .size_i (db_size_i),
      .ok_o   (dec_ok),
      .op_o   (dec_op),
      .n_acc_o(dec_n)
   );

   pce_seq #(
      .MAX_ITEMS (MAX_ITEMS),
      .ADDR_W    (ADDR_W),
      .WBUF_BYTES(WBUF_BYTES),
      .CNT_W     (CNT_W)
   ) i_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ring_i    (db_ring_i),
      .dec_ok_i  (dec_ok),
      .dec_op_i  (dec_op),
      .dec_n_i   (dec_n),
      .wbuf_i    (mbx_wbuf_i),
      .rf_rdata_i(rf_rdata_i),
      .accept_o  (accept),
      .busy_o    (busy_o),
      .finish_o  (finish),
      .rf_en_o   (rf_en_o),
      .rf_we_o   (rf_we_o),
      .rf_addr_o (rf_addr_o),
      .rf_wdata_o(rf_wdata_o),
      .cap_o     (cap),
      .cap_idx_o (cap_idx)
   );

   pce_result #(
      .RBUF_BYTES(RBUF_BYTES),
      .MAX_ITEMS (MAX_ITEMS),
      .CNT_W     (CNT_W)
   ) i_result (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (accept),
      .cap_i    (cap),
      .cap_idx_i(cap_idx),
      .rdata_i  (rf_rdata_i),
      .rbuf_o   (mbx_rbuf_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         ecode_q <= '0;
      end else begin
         done_q <= finish;
         if (accept) begin
            err_q   <= !dec_ok;
            ecode_q <= dec_ok ? '0 : ERR_FORMAT;
         end
      end
   end

   assign done_o     = done_q;
   assign err_o      = err_q;
   assign err_code_o = ecode_q;

   a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   a_r11_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !rf_en_o);

   a_r1_err_code_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (err_o == (err_code_o != '0)));

endmodule

// File: tb/test_pwr_cmd_exec.sv
module test_pwr_cmd_exec;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ring = 1'b0;
   logic [7:0]   code = '0;
   logic [3:0]   sub = '0;
   logic [7:0]   size = '0;
   logic [127:0] wbuf = '0;
   logic [127:0] rbuf;
   logic         done, err, busy, rf_en, rf_we;
   logic [7:0]   ecode, rf_wdata, rf_rdata;
   logic [15:0]  rf_addr;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_cmd_exec i_pwr_cmd_exec (
      .clk_i(clk), .rst_ni(rst_n), .db_ring_i(ring), .db_code_i(code),
      .db_sub_i(sub), .db_size_i(size), .mbx_wbuf_i(wbuf), .mbx_rbuf_o(rbuf),
      .done_o(done), .err_o(err), .err_code_o(ecode), .busy_o(busy),
      .rf_en_o(rf_en), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
      .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
   );

   function automatic logic [7:0] seed_val(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   // register file model and access log
   logic [7:0]  mem [0:255];
   logic [7:0]  rd_q;
   logic [15:0] lg_addr [0:4095];
   logic        lg_we   [0:4095];
   logic [7:0]  lg_wd   [0:4095];
   int          lg_cyc  [0:4095];
   int          lg_n = 0;
   logic [7:0]  sh [0:255];

   assign rf_rdata = rd_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
         rd_q <= '0;
      end else if (rf_en) begin
         if (rf_we) mem[rf_addr[7:0]] <= rf_wdata;
         else rd_q <= mem[rf_addr[7:0]];
         if (lg_n < 4096) begin
            lg_addr[lg_n] <= rf_addr;
            lg_we[lg_n]   <= rf_we;
            lg_wd[lg_n]   <= rf_wdata;
            lg_cyc[lg_n]  <= cyc;
            lg_n          <= lg_n + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // number of register accesses implied by a request, -1 when rejected
   function automatic int model_accesses(logic [7:0] c, logic [3:0] s, logic [7:0] z);
      if (c != 8'hFF) return -1;
      case (s)
         4'd0: return (z % 3 == 0 && z / 3 >= 1 && z / 3 <= 5) ? int'(z) / 3 : -1;
         4'd1: return (z % 2 == 0 && z / 2 >= 1 && z / 2 <= 5) ? int'(z) / 2 : -1;
         4'd2: return (z == 8'd4) ? 2 : -1;
         default: return -1;
      endcase
   endfunction

   task automatic run_cmd(input logic [7:0] c, input logic [3:0] s, input logic [7:0] z,
                          input logic [127:0] wb, input bit intrude);
      int          na, base, k0, t, items;
      bit          bad;
      logic [15:0] ea [0:5];
      bit          ew [0:5];
      logic [7:0]  ed [0:5];
      logic [7:0]  erb [0:15];
      logic [7:0]  old, v, m;
      string       req;
      na  = model_accesses(c, s, z);
      bad = (na < 0);
      if (bad) na = 0;
      for (int i = 0; i < 16; i++) erb[i] = 8'h00;
      for (int i = 0; i < 6; i++) begin ea[i] = '0; ew[i] = 1'b0; ed[i] = '0; end
      req = (c != 8'hFF) ? "R1" : (s > 4'd2) ? "R6" : bad ? "R5" : (s == 4'd0) ? "R2" : (s == 4'd1) ? "R3" : "R4";
      if (!bad) begin
         if (s == 4'd0) begin
            items = na;
            for (int i = 0; i < items; i++) begin
               ea[i] = wb[16*i +: 16];
               ew[i] = 1'b1;
               ed[i] = wb[8*(2*items + i) +: 8];
               sh[ea[i][7:0]] = ed[i];
            end
         end else if (s == 4'd1) begin
            for (int i = 0; i < na; i++) begin
               ea[i]  = wb[16*i +: 16];
               erb[i] = sh[ea[i][7:0]];
            end
         end else begin
            ea[0] = wb[15:0];
            ea[1] = wb[15:0];
            ew[1] = 1'b1;
            old   = sh[ea[0][7:0]];
            v     = wb[23:16];
            m     = wb[31:24];
            ed[1] = (old & ~m) | (v & m);
            sh[ea[0][7:0]] = ed[1];
         end
      end
      @(negedge clk);
      k0   = cyc;
      base = lg_n;
      ring = 1'b1; code = c; sub = s; size = z; wbuf = wb;
      @(negedge clk);
      ring = 1'b0;
      check(busy == 1'b1, "R11 busy after take", 32'(busy), 1);
      if (intrude) begin
         ring = 1'b1; code = 8'hFF; sub = 4'd1; size = 8'd2; wbuf = 128'h00AB;
         @(negedge clk);
         ring = 1'b0;
      end
      t = 0;
      while (!done && t < 40) begin
         @(negedge clk);
         t++;
      end
      check(cyc == k0 + na + 2, "R8 done timing", 32'(cyc), 32'(k0 + na + 2));
      check(busy == 1'b0, "R11 idle at done", 32'(busy), 0);
      check(err == bad, {req, " err flag"}, 32'(err), 32'(bad));
      check(ecode == (bad ? 8'h01 : 8'h00), {req, " err code"}, 32'(ecode), bad ? 1 : 0);
      for (int i = 0; i < 16; i++)
         check(rbuf[8*i +: 8] == erb[i], {req, " R3 read buffer"}, 32'(rbuf[8*i +: 8]), 32'(erb[i]));
      @(negedge clk);
      check(done == 1'b0, "R8 single pulse", 32'(done), 0);
      @(negedge clk);
      @(negedge clk);
      check(done == 1'b0, "R10 no extra done", 32'(done), 0);
      check(err == bad, "R9 err held", 32'(err), 32'(bad));
      check(lg_n - base == na, {req, " R10 access count"}, 32'(lg_n - base), 32'(na));
      for (int i = 0; i < na; i++) begin
         if (base + i < lg_n) begin
            check(lg_addr[base+i] == ea[i], {req, " address"}, 32'(lg_addr[base+i]), 32'(ea[i]));
            check(lg_we[base+i] == ew[i], {req, " direction"}, 32'(lg_we[base+i]), 32'(ew[i]));
            check(lg_cyc[base+i] == k0 + 1 + i, "R7 access cycle", 32'(lg_cyc[base+i]), 32'(k0 + 1 + i));
            if (ew[i])
               check(lg_wd[base+i] == ed[i], {req, " write data"}, 32'(lg_wd[base+i]), 32'(ed[i]));
         end
      end
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : p_main
      logic [127:0] wb;
      int           nn, sel, r;
      logic [7:0]   cc, zz;
      logic [3:0]   ss;
      void'($urandom(32'd2718));
      for (int i = 0; i < 256; i++) sh[i] = seed_val(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(busy == 0 && done == 0 && err == 0, "R12 reset flags", {29'd0, busy, done, err}, 0);
      check(rf_en == 1'b0, "R12 no access", 32'(rf_en), 0);
      check(rbuf == '0, "R12 read buffer", 32'(rbuf[31:0]), 0);

      // R2 five-item write with a doorbell arriving mid-batch (R10)
      wb = '0;
      for (int i = 0; i < 5; i++) begin
         wb[16*i +: 16]     = 16'h1200 + 16'(i * 3);
         wb[8*(10 + i) +: 8] = 8'hA0 + 8'(i);
      end
      run_cmd(8'hFF, 4'd0, 8'd15, wb, 1'b1);
      // R3 read them back, addresses in reverse order
      wb = '0;
      for (int i = 0; i < 5; i++) wb[16*i +: 16] = 16'h1200 + 16'((4 - i) * 3);
      run_cmd(8'hFF, 4'd1, 8'd10, wb, 1'b0);
      // R4 masked update
      run_cmd(8'hFF, 4'd2, 8'd4, {96'd0, 8'h0F, 8'h5A, 16'h1203}, 1'b0);
      run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h1203}, 1'b0);
      // R5 malformed sizes
      run_cmd(8'hFF, 4'd0, 8'd0, wb, 1'b0);
      run_cmd(8'hFF, 4'd0, 8'd7, wb, 1'b0);
      run_cmd(8'hFF, 4'd1, 8'd12, wb, 1'b0);
      run_cmd(8'hFF, 4'd0, 8'd18, wb, 1'b0);
      run_cmd(8'hFF, 4'd2, 8'd5, wb, 1'b0);
      // R6 unknown sub-command, R1 wrong code
      run_cmd(8'hFF, 4'd3, 8'd4, wb, 1'b0);
      run_cmd(8'hFE, 4'd1, 8'd2, wb, 1'b0);
      // R9 success after error clears the flag
      run_cmd(8'hFF, 4'd1, 8'd2, {112'd0, 16'h1206}, 1'b0);

      // constrained random mix
      for (int k = 0; k < 80; k++) begin
         nn  = 1 + int'($urandom % 5);
         sel = int'($urandom % 3);
         ss  = 4'(sel);
         zz  = (sel == 0) ? 8'(3 * nn) : (sel == 1) ? 8'(2 * nn) : 8'd4;
         cc  = 8'hFF;
         wb  = {$urandom, $urandom, $urandom, $urandom};
         r   = int'($urandom % 10);
         if (r == 0) zz = zz + 8'd1;
         else if (r == 1) cc = 8'($urandom % 255);
         else if (r == 2) ss = 4'(3 + $urandom % 13);
         run_cmd(cc, ss, zz, wb, 1'b0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule